// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a simple in-order fetch stage and works out, every cycle, the address of the next instruction. It decodes the instruction word for three kinds of control transfer. The first is a pseudo-absolute jump built from a 26-bit target. The second is a jump to the address held in a register. The third is a PC-relative branch. The branch conditions are evaluated inside the block, from the two register values that the register file supplies for the current instruction. Any other instruction simply advances the PC by one word.

The next address and a flag saying that control left the sequential path are available combinationally. The PC register takes the next address on a rising clock edge while the step enable is high, so the surrounding stage can stall fetch by lowering the enable. The reset is asynchronous and active low, and it puts the PC at address zero.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0, and it stays 0 until the first enabled clock edge after release.
- R2: On a rising edge with `step_en` high, `pc_q` takes the value `pc_next` had before the edge. With `step_en` low, `pc_q` holds its value.
- R3: For an opcode (`instr[31:26]`) outside 0..7, `pc_next` is `pc_q + 4` and `taken` is 0. The same holds for opcode 0 when the function field `instr[5:0]` is not 0x08.
- R4: For opcode 2 (plain jump) and opcode 3 (jump with link), `pc_next` is `{(pc_q+4)[31:28], instr[25:0], 2'b00}` and `taken` is 1.
- R5: For opcode 0 with function field 0x08 (register jump), `pc_next` equals `reg_a` and `taken` is 1.
- R6: Opcode 4 is taken when `reg_a == reg_b`. Opcode 5 is taken when the two differ.
- R7: Opcode 6 is taken when `reg_a`, read as signed, is zero or negative. Opcode 7 is taken when it is strictly positive.
- R8: For opcode 1, the field `instr[20:16]` selects the test. Value 0 is taken when `reg_a` is negative, and value 1 is taken when `reg_a` is zero or positive. Any other value is never taken.
- R9: A taken branch sets `pc_next` to `pc_q + 4 + (sign_extend(instr[15:0]) << 2)` and `taken` to 1. A branch that is not taken gives `pc_q + 4` with `taken` at 0.
- R10: The branch target addition wraps modulo 2^32, so a negative offset near address 0 lands at the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Load `pc_next` into the PC on this edge |
| instr | input | 32 | Instruction word fetched at `pc_q` |
| reg_a | input | 32 | Value of the first source register (rs field) |
| reg_b | input | 32 | Value of the second source register (rt field) |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Address of the next instruction |
| taken | output | 1 | Control leaves the sequential path |

## Verification
A branch decision and a stalled register update can fall in the same cycle. The condition logic resolves a taken branch and drives its target on `pc_next` while `step_en` is low, so the PC must not take it. The bench provokes this with a taken equality branch issued under a low enable. It judges the result by checking that the following item still sees the old `pc_q` and then computes the same target once the enable returns.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int OPC_W = 6;
   localparam int FN_W  = 6;
   localparam int SUB_W = 5;

   localparam logic [OPC_W-1:0] OPC_REGGRP  = 6'd0;
   localparam logic [OPC_W-1:0] OPC_SIGNGRP = 6'd1;
   localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JLINK   = 6'd3;
   localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'd5;
   localparam logic [OPC_W-1:0] OPC_BR_LEZ  = 6'd6;
   localparam logic [OPC_W-1:0] OPC_BR_GTZ  = 6'd7;

   localparam logic [FN_W-1:0]  FN_REGJUMP  = 6'h08;

   localparam logic [SUB_W-1:0] SUB_LTZ     = 5'd0;
   localparam logic [SUB_W-1:0] SUB_GEZ     = 5'd1;

   typedef enum logic [1:0] {
      SEL_SEQ,
      SEL_ABS,
      SEL_REG,
      SEL_REL
   } tgt_sel_e;

   typedef enum logic [2:0] {
      CND_NONE,
      CND_ALWAYS,
      CND_EQ,
      CND_NE,
      CND_LEZ,
      CND_GTZ,
      CND_LTZ,
      CND_GEZ
   } cond_e;

   typedef struct packed {
      tgt_sel_e sel;
      cond_e    cond;
   } flow_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic [SUB_W-1:0] subop,
   input  logic [FN_W-1:0]  funct,
   output flow_t            flow
);

   always_comb begin
      flow.sel  = SEL_SEQ;
      flow.cond = CND_NONE;
      unique case (opcode)
         OPC_REGGRP: begin
            if (funct == FN_REGJUMP) begin
               flow.sel  = SEL_REG;
               flow.cond = CND_ALWAYS;
            end
         end
         OPC_SIGNGRP: begin
            if (subop == SUB_LTZ) begin
               flow.sel  = SEL_REL;
               flow.cond = CND_LTZ;
            end else if (subop == SUB_GEZ) begin
               flow.sel  = SEL_REL;
               flow.cond = CND_GEZ;
            end
         end
         OPC_JUMP, OPC_JLINK: begin
            flow.sel  = SEL_ABS;
            flow.cond = CND_ALWAYS;
         end
         OPC_BR_EQ: begin
            flow.sel  = SEL_REL;
            flow.cond = CND_EQ;
         end
         OPC_BR_NE: begin
            flow.sel  = SEL_REL;
            flow.cond = CND_NE;
         end
         OPC_BR_LEZ: begin
            flow.sel  = SEL_REL;
            flow.cond = CND_LEZ;
         end
         OPC_BR_GTZ: begin
            flow.sel  = SEL_REL;
            flow.cond = CND_GTZ;
         end
         default: begin
            flow.sel  = SEL_SEQ;
            flow.cond = CND_NONE;
         end
      endcase
   end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  cond_e             cond,
   input  logic [XLEN-1:0]   opnd_a,
   input  logic [XLEN-1:0]   opnd_b,
   output logic              pass
);

   logic a_neg;
   logic a_zero;
   logic same;

   assign a_neg  = opnd_a[XLEN-1];
   assign a_zero = (opnd_a == '0);
   assign same   = (opnd_a == opnd_b);

   always_comb begin
      unique case (cond)
         CND_ALWAYS: pass = 1'b1;
         CND_EQ:     pass = same;
         CND_NE:     pass = !same;
         CND_LEZ:    pass = a_neg || a_zero;
         CND_GTZ:    pass = !a_neg && !a_zero;
         CND_LTZ:    pass = a_neg;
         CND_GEZ:    pass = !a_neg;
         default:    pass = 1'b0;
      endcase
   end

endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int IMM_W        = 16,
   parameter int TGT_W        = 26,
   parameter bit SHARED_ADDER = 1'b0
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [IMM_W-1:0] imm,
   input  logic [TGT_W-1:0] jtgt,
   input  logic [XLEN-1:0]  reg_val,
   input  tgt_sel_e         sel,
   input  logic             pass,
   output logic [XLEN-1:0]  next,
   output logic             taken
);

   localparam int HI_W  = XLEN - TGT_W - 2;
   localparam int EXT_W = XLEN - IMM_W - 2;
   localparam logic [XLEN-1:0] WORD_STEP = {{(XLEN-3){1'b0}}, 3'b100};

   logic [XLEN-1:0] offs;
   logic [XLEN-1:0] seq_addr;
   logic [XLEN-1:0] rel_addr;
   logic [XLEN-1:0] abs_addr;
   logic            take_rel;

   assign offs     = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign take_rel = (sel == SEL_REL) && pass;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [XLEN-1:0] sum;
         assign sum      = pc + WORD_STEP + (take_rel ? offs : '0);
         assign seq_addr = sum;
         assign rel_addr = sum;
      end else begin : g_parallel
         assign seq_addr = pc + WORD_STEP;
         assign rel_addr = seq_addr + offs;
      end
   endgenerate

   assign abs_addr = {seq_addr[XLEN-1 -: HI_W], jtgt, 2'b00};

   always_comb begin
      next  = seq_addr;
      taken = 1'b0;
      unique case (sel)
         SEL_ABS: begin
            next  = abs_addr;
            taken = 1'b1;
         end
         SEL_REG: begin
            next  = reg_val;
            taken = 1'b1;
         end
         SEL_REL: begin
            if (take_rel) begin
               next  = rel_addr;
               taken = 1'b1;
            end
         end
         default: begin
            next  = seq_addr;
            taken = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter int          IMM_W        = 16,
   parameter int          TGT_W        = 26,
   parameter bit          SHARED_ADDER = 1'b0,
   parameter logic [31:0] RESET_ADDR   = 32'h0000_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_en,
   input  logic [XLEN-1:0] instr,
   input  logic [XLEN-1:0] reg_a,
   input  logic [XLEN-1:0] reg_b,
   output logic [XLEN-1:0] pc_q,
   output logic [XLEN-1:0] pc_next,
   output logic            taken
);

   localparam int SUB_LO = IMM_W;
   localparam int FN_LO  = 0;

   generate
      if (XLEN != OPC_W + TGT_W) begin : g_bad_jump_layout
         $error("npc_unit: XLEN must equal opcode width plus jump target width");
      end
      if (IMM_W + 2 > XLEN) begin : g_bad_imm
         $error("npc_unit: immediate too wide for XLEN");
      end
      if (TGT_W + 2 >= XLEN) begin : g_bad_tgt
         $error("npc_unit: jump target leaves no upper PC bits");
      end
      if (IMM_W + SUB_W > TGT_W) begin : g_bad_fields
         $error("npc_unit: sub-opcode field overlaps the opcode");
      end
   endgenerate

   flow_t flow;
   logic  cond_pass;

   npc_decode u_decode (
      .opcode (instr[XLEN-1 -: OPC_W]),
      .subop  (instr[SUB_LO +: SUB_W]),
      .funct  (instr[FN_LO +: FN_W]),
      .flow   (flow)
   );

   npc_cond #(
      .XLEN (XLEN)
   ) u_cond (
      .cond   (flow.cond),
      .opnd_a (reg_a),
      .opnd_b (reg_b),
      .pass   (cond_pass)
   );

   npc_target #(
      .XLEN         (XLEN),
      .IMM_W        (IMM_W),
      .TGT_W        (TGT_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_target (
      .pc      (pc_q),
      .imm     (instr[IMM_W-1:0]),
      .jtgt    (instr[TGT_W-1:0]),
      .reg_val (reg_a),
      .sel     (flow.sel),
      .pass    (cond_pass),
      .next    (pc_next),
      .taken   (taken)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= XLEN'(RESET_ADDR);
      end else if (step_en) begin
         pc_q <= pc_next;
      end
   end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int          XLEN       = 32,
   parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
   input logic            clk,
   input logic            rst_n,
   input logic            step_en,
   input logic [XLEN-1:0] instr,
   input logic [XLEN-1:0] reg_a,
   input logic [XLEN-1:0] pc_q,
   input logic [XLEN-1:0] pc_next,
   input logic            taken
);

   logic [5:0]      op;
   logic [XLEN-1:0] seq;
   assign op  = instr[XLEN-1 -: 6];
   assign seq = pc_q + XLEN'(4);

   // R1: the PC sits at the reset address one edge after reset is seen low
   assert_reset_addr_R1: assert property (@(posedge clk)
      !rst_n |=> (pc_q == XLEN'(RESET_ADDR)));

   // R2: an enabled edge loads the computed address
   assert_step_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> (pc_q == $past(pc_next)));

   // R2: a disabled edge keeps the PC
   assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(pc_q));

   // R4: jumps always redirect to a word-aligned address
   assert_jump_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'd2 || op == 6'd3) |-> (taken && pc_next[1:0] == 2'b00));

   // R5: a register jump follows the register
   assert_regjump_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'd0 && instr[5:0] == 6'h08) |-> (taken && pc_next == reg_a));

   // R9: without a redirect the fetch advances one word
   assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> (pc_next == seq));

   // R3: opcodes above 7 never redirect
   assert_other_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op > 6'd7) |-> !taken);

endmodule

bind npc_unit npc_unit_chk #(
   .XLEN       (XLEN),
   .RESET_ADDR (RESET_ADDR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .step_en (step_en),
   .instr   (instr),
   .reg_a   (reg_a),
   .pc_q    (pc_q),
   .pc_next (pc_next),
   .taken   (taken)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0;
   logic [31:0] instr = 32'h0;
   logic [31:0] reg_a = 32'h0;
   logic [31:0] reg_b = 32'h0;
   logic [31:0] pc_q;
   logic [31:0] pc_next;
   logic        taken;

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct {
      logic [31:0] pc;
      logic [31:0] nxt;
      logic        tk;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   logic [31:0] model_pc = 32'h0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   npc_unit uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .instr   (instr),
      .reg_a   (reg_a),
      .reg_b   (reg_b),
      .pc_q    (pc_q),
      .pc_next (pc_next),
      .taken   (taken)
   );

   function automatic logic [31:0] mk_imm(input logic [5:0] op, input logic [4:0] rt,
                                          input logic [15:0] imm);
      return {op, 5'd9, rt, imm};
   endfunction

   function automatic logic [31:0] mk_jmp(input logic [5:0] op, input logic [25:0] t);
      return {op, t};
   endfunction

   function automatic logic [31:0] mk_reg(input logic [5:0] fn);
      return {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, fn};
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Driver: applies one instruction and records what the ports must show
   task automatic drive(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic stp, input string tag);
      logic [31:0] p4;
      logic [31:0] off;
      logic [31:0] nx;
      logic        tk;
      logic        cnd;
      logic        is_rel;
      exp_t        e;
      @(negedge clk);
      instr   = ins;
      reg_a   = a;
      reg_b   = b;
      step_en = stp;
      p4      = model_pc + 32'd4;
      off     = {{14{ins[15]}}, ins[15:0], 2'b00};
      nx      = p4;
      tk      = 1'b0;
      cnd     = 1'b0;
      is_rel  = 1'b0;
      case (ins[31:26])
         6'd0: if (ins[5:0] == 6'h08) begin nx = a; tk = 1'b1; end
         6'd1: begin
            if (ins[20:16] == 5'd0) begin is_rel = 1'b1; cnd = $signed(a) < 0; end
            else if (ins[20:16] == 5'd1) begin is_rel = 1'b1; cnd = $signed(a) >= 0; end
         end
         6'd2, 6'd3: begin nx = {p4[31:28], ins[25:0], 2'b00}; tk = 1'b1; end
         6'd4: begin is_rel = 1'b1; cnd = (a == b); end
         6'd5: begin is_rel = 1'b1; cnd = (a != b); end
         6'd6: begin is_rel = 1'b1; cnd = $signed(a) <= 0; end
         6'd7: begin is_rel = 1'b1; cnd = $signed(a) > 0; end
         default: ;
      endcase
      if (is_rel && cnd) begin
         nx = p4 + off;
         tk = 1'b1;
      end
      e.pc  = model_pc;
      e.nxt = nx;
      e.tk  = tk;
      e.tag = tag;
      sb_q.push_back(e);
      if (stp) model_pc = nx;
   endtask

   // Monitor: compares the ports a quarter period after each drive point
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "pc_q", pc_q, e.pc);
            check(e.tag, "pc_next", pc_next, e.nxt);
            check(e.tag, "taken", {31'd0, taken}, {31'd0, e.tk});
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 4000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", "pc_q in reset", pc_q, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", "pc_q after release", pc_q, 32'h0);

      // R3: ordinary instruction and unlisted register-group function
      drive(mk_imm(6'h23, 5'd3, 16'h0010), 32'h5, 32'h5, 1'b1, "R3");
      drive(mk_reg(6'h20), 32'h1234_5678, 32'h0, 1'b1, "R3");
      // R5: register jump relocates the PC
      drive(mk_reg(6'h08), 32'h1000_0000, 32'h0, 1'b1, "R5");
      // R4: plain jump keeps the upper four bits of PC+4
      drive(mk_jmp(6'd2, 26'h0AB_CDEF), 32'h0, 32'h0, 1'b1, "R4");
      drive(mk_jmp(6'd3, 26'h000_0040), 32'h0, 32'h0, 1'b1, "R4");
      // R6 and R9: equality branch taken then not taken
      drive(mk_imm(6'd4, 5'd0, 16'h0008), 32'h77, 32'h77, 1'b1, "R6");
      drive(mk_imm(6'd4, 5'd0, 16'h0008), 32'h77, 32'h78, 1'b1, "R9");
      drive(mk_imm(6'd5, 5'd0, 16'hFFFE), 32'h1, 32'h2, 1'b1, "R6");
      drive(mk_imm(6'd5, 5'd0, 16'hFFFE), 32'h3, 32'h3, 1'b1, "R9");
      // R7: sign tests against zero
      drive(mk_imm(6'd6, 5'd0, 16'h0004), 32'h0, 32'h0, 1'b1, "R7");
      drive(mk_imm(6'd6, 5'd0, 16'h0004), 32'hFFFF_FFFB, 32'h0, 1'b1, "R7");
      drive(mk_imm(6'd6, 5'd0, 16'h0004), 32'h5, 32'h0, 1'b1, "R7");
      drive(mk_imm(6'd7, 5'd0, 16'h0003), 32'h0, 32'h0, 1'b1, "R7");
      drive(mk_imm(6'd7, 5'd0, 16'h0003), 32'h7FFF_FFFF, 32'h0, 1'b1, "R7");
      // R8: single-register group selected by the rt field
      drive(mk_imm(6'd1, 5'd0, 16'h0002), 32'h8000_0000, 32'h0, 1'b1, "R8");
      drive(mk_imm(6'd1, 5'd0, 16'h0002), 32'h0, 32'h0, 1'b1, "R8");
      drive(mk_imm(6'd1, 5'd1, 16'h0002), 32'h0, 32'h0, 1'b1, "R8");
      drive(mk_imm(6'd1, 5'd1, 16'h0002), 32'hFFFF_FFFF, 32'h0, 1'b1, "R8");
      drive(mk_imm(6'd1, 5'd2, 16'h0002), 32'hFFFF_FFFF, 32'h0, 1'b1, "R8");
      // R2: taken branch under a low enable must not move the PC
      drive(mk_imm(6'd4, 5'd0, 16'h0100), 32'h9, 32'h9, 1'b0, "R2");
      drive(mk_imm(6'd4, 5'd0, 16'h0100), 32'h9, 32'h9, 1'b0, "R2");
      drive(mk_imm(6'd4, 5'd0, 16'h0100), 32'h9, 32'h9, 1'b1, "R2");
      // R10: negative offset near zero wraps to the top of memory
      drive(mk_reg(6'h08), 32'h0000_0004, 32'h0, 1'b1, "R5");
      drive(mk_imm(6'd4, 5'd0, 16'hFFFC), 32'h0, 32'h0, 1'b1, "R10");
      drive(mk_imm(6'h0F, 5'd0, 16'h0000), 32'h0, 32'h0, 1'b1, "R10");
      // R3: opcode above the control range
      drive(mk_imm(6'h3F, 5'd1, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, 1'b0, "R3");

      repeat (2) @(negedge clk);
      #(CLK_PERIOD/2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule